// File: doc/BRIEF.md
# Memory-to-Memory Instruction Sequencer

This block is a multi-cycle controller for a machine whose instructions name every operand by memory address. Each instruction carries an operation, a branch condition, a destination address, two source addresses and two explicit next-instruction addresses. Nothing is stepped implicitly: the address of the following instruction always comes from one of the two next-address fields, chosen by testing the freshly computed result.

The sequencer owns one synchronous memory port. It presents an address with a read strobe or a write strobe, and read data returns on the cycle after the strobe. For each instruction it fetches six words, decodes them, reads the first operand and, when needed, the second, applies a small add/subtract ALU, writes the result back and moves to the selected next address. A halt operation parks the sequencer and raises an output.

Top module: `mm_mem_seq`

## Requirements
- R1: While reset is held and afterwards, `halted` is low and no write is issued. The first access after reset is a read of word address 0.
- R2: An instruction at address P is fetched as six reads at P..P+5, one strobe per word. Word 0 holds the opcode in bits [5:0] and the condition in bits [9:6]; bits [15:10] are ignored. Words 1..5 are the destination, source-1, source-2, true-target and false-target addresses.
- R3: A memory step never asserts read and write together. Read data is taken on the cycle after its strobe.
- R4: Opcode 0 (add) stores source-1 plus source-2, modulo 2^16, at the destination.
- R5: Opcode 1 (subtract) stores source-1 minus source-2, modulo 2^16, at the destination.
- R6: Opcode 2 (move) stores source-1 at the destination and issues no read of the source-2 address.
- R7: Condition 0, and every condition from 3 to 15, always continues at the true target.
- R8: Condition 1 continues at the true target when the stored result is zero and at the false target otherwise.
- R9: Condition 2 continues at the true target when the stored result is nonzero and at the false target otherwise.
- R10: Opcode 3, and every opcode from 4 to 63, raises `halted` after its fetch. It writes nothing, and no further strobe follows.
- R11: Each add, subtract or move issues exactly one write, to the destination address, after its operand reads. Source words stay unchanged unless they are the destination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Word address of the current memory step |
| mem_rd | output | 1 | Read strobe; data is expected on `mem_rdata` one cycle later |
| mem_wr | output | 1 | Write strobe for `mem_wdata` at `mem_addr` |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data from memory |
| halted | output | 1 | High once a halt opcode has been decoded |

## Verification
Add is tried with plain operands and with operands that carry past 16 bits, so a missing modulo wrap shows up. Subtract runs with equal operands and with a minuend below the subtrahend. This separates the zero and nonzero branch conditions and checks that a negative difference wraps. Each target instruction writes a distinct marker, so the path taken is visible in memory. Strobe counts and a probe on the second-source address tell move apart from a two-operand operation. Halt opcodes are checked to leave the memory port silent.

// File: rtl/mm_seq_pkg.sv
package mm_seq_pkg;

  typedef enum logic [2:0] {
    S_FETCH  = 3'd0,
    S_DECODE = 3'd1,
    S_RD1    = 3'd2,
    S_RD2    = 3'd3,
    S_EXEC   = 3'd4,
    S_WB     = 3'd5,
    S_HALT   = 3'd6
  } seq_state_t;

  localparam logic [5:0] OP_ADD  = 6'd0;
  localparam logic [5:0] OP_SUB  = 6'd1;
  localparam logic [5:0] OP_MOV  = 6'd2;

  localparam logic [3:0] CC_ALWAYS = 4'd0;
  localparam logic [3:0] CC_ZERO   = 4'd1;
  localparam logic [3:0] CC_NZERO  = 4'd2;

  // address field positions inside the operand block (fetch words 1..5)
  localparam int FLD_DST = 0;
  localparam int FLD_SRC1 = 1;
  localparam int FLD_SRC2 = 2;
  localparam int FLD_TRUE = 3;
  localparam int FLD_FALSE = 4;
  localparam int NUM_FLD = 5;

  function automatic logic op_runs(input logic [5:0] op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MOV);
  endfunction

  function automatic logic cond_hit(input logic [3:0] cc, input logic is_zero);
    case (cc)
      CC_ZERO:  return is_zero;
      CC_NZERO: return !is_zero;
      default:  return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/mm_instr_reg.sv
module mm_instr_reg #(
  parameter int DW = 16,
  parameter int NF = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [2:0]         idx,
  input  logic [DW-1:0]      word,
  output logic [5:0]         op,
  output logic [3:0]         cond,
  output logic [NF-1:0][DW-1:0] fields
);
  logic unused_hi;
  assign unused_hi = ^word[DW-1:10];

  always_ff @(posedge clk) begin
    if (rst) begin
      op   <= '0;
      cond <= '0;
    end else if (load && idx == 3'd0) begin
      op   <= word[5:0];
      cond <= word[9:6];
    end
  end

  for (genvar g = 0; g < NF; g++) begin : g_fld
    logic [DW-1:0] fld_q;
    always_ff @(posedge clk) begin
      if (rst) fld_q <= '0;
      else if (load && idx == 3'(g + 1)) fld_q <= word;
    end
    assign fields[g] = fld_q;
  end
endmodule

// File: rtl/mm_alu.sv
module mm_alu #(
  parameter int DW = 16
) (
  input  logic [5:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y,
  output logic          zero
);
  import mm_seq_pkg::*;

  function automatic logic [DW-1:0] f_alu(input logic [5:0] o,
                                          input logic [DW-1:0] x,
                                          input logic [DW-1:0] z);
    case (o)
      OP_SUB:  return x - z;
      OP_MOV:  return x;
      default: return x + z;
    endcase
  endfunction

  assign y    = f_alu(op, a, b);
  assign zero = (y == '0);
endmodule

// File: rtl/mm_next_sel.sv
module mm_next_sel #(
  parameter int AW = 16
) (
  input  logic [3:0]    cond,
  input  logic          res_zero,
  input  logic [AW-1:0] tgt_true,
  input  logic [AW-1:0] tgt_false,
  output logic          take_true,
  output logic [AW-1:0] next_addr
);
  import mm_seq_pkg::*;
  assign take_true = cond_hit(cond, res_zero);
  assign next_addr = take_true ? tgt_true : tgt_false;
endmodule

// File: rtl/mm_mem_seq.sv
module mm_mem_seq #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  output logic [DW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          halted
);
  import mm_seq_pkg::*;

  localparam int AW = DW;
  localparam int NWORDS = NUM_FLD + 1;
  localparam logic [2:0] LAST_W = 3'(NWORDS - 1);

  seq_state_t state;
  logic          ph;
  logic [2:0]    widx;
  logic [AW-1:0] pc;
  logic [DW-1:0] opa, opb, res;
  logic          res_zero;

  logic [5:0]    ir_op;
  logic [3:0]    ir_cond;
  logic [NUM_FLD-1:0][AW-1:0] ir_fld;
  logic [DW-1:0] alu_y;
  logic          alu_zero;
  logic          take_true;
  logic [AW-1:0] nxt;

  // named internal events
  logic word_cap, src1_cap, src2_cap, wb_fire;
  assign word_cap = (state == S_FETCH) && ph;
  assign src1_cap = (state == S_RD1) && ph;
  assign src2_cap = (state == S_RD2) && ph;
  assign wb_fire  = (state == S_WB);

  mm_instr_reg #(.DW(DW), .NF(NUM_FLD)) u_ir (
    .clk(clk), .rst(rst), .load(word_cap), .idx(widx), .word(mem_rdata),
    .op(ir_op), .cond(ir_cond), .fields(ir_fld)
  );

  mm_alu #(.DW(DW)) u_alu (
    .op(ir_op), .a(opa), .b(opb), .y(alu_y), .zero(alu_zero)
  );

  mm_next_sel #(.AW(AW)) u_nsel (
    .cond(ir_cond), .res_zero(res_zero),
    .tgt_true(ir_fld[FLD_TRUE]), .tgt_false(ir_fld[FLD_FALSE]),
    .take_true(take_true), .next_addr(nxt)
  );

  always_comb begin
    mem_addr  = '0;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_wdata = res;
    case (state)
      S_FETCH: begin mem_addr = pc + AW'(widx);     mem_rd = !ph; end
      S_RD1:   begin mem_addr = ir_fld[FLD_SRC1];   mem_rd = !ph; end
      S_RD2:   begin mem_addr = ir_fld[FLD_SRC2];   mem_rd = !ph; end
      S_WB:    begin mem_addr = ir_fld[FLD_DST];    mem_wr = 1'b1; end
      default: ;
    endcase
  end

  assign halted = (state == S_HALT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_FETCH;
      ph       <= 1'b0;
      widx     <= '0;
      pc       <= '0;
      opa      <= '0;
      opb      <= '0;
      res      <= '0;
      res_zero <= 1'b0;
    end else begin
      case (state)
        S_FETCH: begin
          ph <= !ph;
          if (ph) begin
            if (widx == LAST_W) begin
              widx  <= '0;
              state <= S_DECODE;
            end else begin
              widx <= widx + 3'd1;
            end
          end
        end
        S_DECODE: state <= op_runs(ir_op) ? S_RD1 : S_HALT;
        S_RD1: begin
          ph <= !ph;
          if (ph) begin
            opa   <= mem_rdata;
            state <= (ir_op == OP_MOV) ? S_EXEC : S_RD2;
          end
        end
        S_RD2: begin
          ph <= !ph;
          if (ph) begin
            opb   <= mem_rdata;
            state <= S_EXEC;
          end
        end
        S_EXEC: begin
          res      <= alu_y;
          res_zero <= alu_zero;
          state    <= S_WB;
        end
        S_WB: begin
          pc    <= nxt;
          state <= S_FETCH;
        end
        default: state <= S_HALT;
      endcase
    end
  end

  // ---------------- assertions ----------------
  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!mem_rd && !mem_wr));

  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  assert_write_after_exec_R11: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> $past(state == S_EXEC));

  assert_next_fetch_R8: assert property (@(posedge clk) disable iff (rst)
    wb_fire |=> (mem_rd && mem_addr == $past(nxt)));

  assert_fetch_seq_R2: assert property (@(posedge clk) disable iff (rst)
    (state == S_FETCH && !ph && widx != 3'd0) |->
      (mem_addr == AW'($past(mem_addr, 2) + AW'(1))));

  assert_mov_skip_R6: assert property (@(posedge clk) disable iff (rst)
    src1_cap |=> !(ir_op == OP_MOV && mem_rd));

  assert_src2_only_rd_R3: assert property (@(posedge clk) disable iff (rst)
    src2_cap |-> $past(mem_rd));
endmodule

// File: tb/mm_mem_seq_tb.sv
`timescale 1ns/1ps
module mm_mem_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr, halted;

  logic [15:0] mem [0:1023];
  int n_chk = 0, n_bad = 0;
  int rd_cnt, wr_cnt;
  logic probe_hit;
  logic [15:0] probe_addr = 16'h3FF;

  localparam logic [15:0] T_ADDR = 16'h0040;
  localparam logic [15:0] F_ADDR = 16'h0048;
  localparam logic [15:0] H_ADDR = 16'h0050;
  localparam logic [15:0] MARK_T = 16'hAAAA;
  localparam logic [15:0] MARK_F = 16'hBBBB;

  always #2.5 clk = ~clk;

  mm_mem_seq u_dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .halted(halted)
  );

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
    if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
    if (rst) begin
      rd_cnt <= 0; wr_cnt <= 0; probe_hit <= 1'b0;
    end else begin
      if (mem_rd) rd_cnt <= rd_cnt + 1;
      if (mem_wr) wr_cnt <= wr_cnt + 1;
      if (mem_rd && mem_addr == probe_addr) probe_hit <= 1'b1;
    end
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put_instr(input logic [15:0] a, input logic [5:0] op,
                           input logic [3:0] cc, input logic [5:0] junk,
                           input logic [15:0] d, input logic [15:0] s1,
                           input logic [15:0] s2, input logic [15:0] t,
                           input logic [15:0] f);
    mem[a[9:0]]       = {junk, cc, op};
    mem[a[9:0] + 10'd1] = d;
    mem[a[9:0] + 10'd2] = s1;
    mem[a[9:0] + 10'd3] = s2;
    mem[a[9:0] + 10'd4] = t;
    mem[a[9:0] + 10'd5] = f;
  endtask

  // clear memory, install the two branch targets and the final halt
  task automatic base_image();
    rst = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0;
    put_instr(T_ADDR, 6'd2, 4'd0, 6'd0, 16'd200, 16'd201, 16'd0, H_ADDR, H_ADDR);
    put_instr(F_ADDR, 6'd2, 4'd0, 6'd0, 16'd200, 16'd202, 16'd0, H_ADDR, H_ADDR);
    put_instr(H_ADDR, 6'd3, 4'd0, 6'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0);
    mem[201] = MARK_T;
    mem[202] = MARK_F;
  endtask

  task automatic run_prog();
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 3000 && !halted; i++) @(negedge clk);
    chk(halted, "R10", "run ended halted", {31'd0, halted}, 32'd1);
  endtask

  task automatic alu_case(input string req, input logic [5:0] op,
                          input logic [3:0] cc, input logic [15:0] a,
                          input logic [15:0] b, input logic [15:0] exp_res,
                          input logic exp_true);
    base_image();
    put_instr(16'h0, op, cc, 6'h3F, 16'd100, 16'd101, 16'd102, T_ADDR, F_ADDR);
    mem[101] = a;
    mem[102] = b;
    run_prog();
    chk(mem[100] == exp_res, req, "result at destination", {16'd0, mem[100]}, {16'd0, exp_res});
    chk(mem[200] == (exp_true ? MARK_T : MARK_F), req, "branch marker",
        {16'd0, mem[200]}, {16'd0, exp_true ? MARK_T : MARK_F});
    chk(mem[101] == a, "R11", "source-1 untouched", {16'd0, mem[101]}, {16'd0, a});
    chk(wr_cnt == 2, "R11", "write count", wr_cnt, 2);
    chk(rd_cnt == 21, "R2", "read count", rd_cnt, 21);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(!halted, "R1", "halted in reset", {31'd0, halted}, 0);
    chk(!mem_wr, "R1", "no write in reset", {31'd0, mem_wr}, 0);
    rst = 1'b0;
    #1;
    chk(mem_rd && mem_addr == 16'h0, "R1", "first access read of 0",
        {15'd0, mem_rd, mem_addr}, {15'd0, 1'b1, 16'h0});
    @(negedge clk);
    chk(!mem_rd && !mem_wr, "R3", "idle cycle after strobe",
        {30'd0, mem_rd, mem_wr}, 0);
    rst = 1'b1;
  endtask

  task automatic t_add();
    alu_case("R4", 6'd0, 4'd0, 16'h1234, 16'h0F0F, 16'h2143, 1'b1);
    alu_case("R4", 6'd0, 4'd0, 16'hFFFF, 16'h0002, 16'h0001, 1'b1);
  endtask

  task automatic t_sub_nz();
    alu_case("R9", 6'd1, 4'd2, 16'd5, 16'd3, 16'd2, 1'b1);
    alu_case("R9", 6'd1, 4'd2, 16'd7, 16'd7, 16'd0, 1'b0);
  endtask

  task automatic t_sub_z();
    alu_case("R8", 6'd1, 4'd1, 16'd7, 16'd7, 16'd0, 1'b1);
    alu_case("R5", 6'd1, 4'd1, 16'd3, 16'd5, 16'hFFFE, 1'b0);
  endtask

  task automatic t_cond_other();
    alu_case("R7", 6'd1, 4'd9, 16'd4, 16'd4, 16'd0, 1'b1);
    alu_case("R7", 6'd1, 4'd0, 16'd4, 16'd4, 16'd0, 1'b1);
  endtask

  task automatic t_mov();
    base_image();
    probe_addr = 16'd302;
    put_instr(16'h0, 6'd2, 4'd1, 6'd0, 16'd300, 16'd301, 16'd302, T_ADDR, F_ADDR);
    mem[301] = 16'h5A5A;
    mem[302] = 16'h1111;
    run_prog();
    chk(mem[300] == 16'h5A5A, "R6", "move copies source-1", {16'd0, mem[300]}, 32'h5A5A);
    chk(!probe_hit, "R6", "no read of source-2", {31'd0, probe_hit}, 0);
    chk(rd_cnt == 20, "R6", "read count", rd_cnt, 20);
    chk(mem[200] == MARK_F, "R8", "nonzero move takes false", {16'd0, mem[200]}, {16'd0, MARK_F});
    probe_addr = 16'h3FF;
  endtask

  task automatic t_halt(input logic [5:0] op);
    base_image();
    put_instr(16'h0, op, 4'd0, 6'd0, 16'd100, 16'd101, 16'd102, T_ADDR, F_ADDR);
    mem[100] = 16'hCAFE;
    run_prog();
    repeat (10) @(negedge clk);
    chk(rd_cnt == 6, "R10", "only fetch reads", rd_cnt, 6);
    chk(wr_cnt == 0, "R10", "no write", wr_cnt, 0);
    chk(mem[100] == 16'hCAFE, "R10", "destination unchanged", {16'd0, mem[100]}, 32'hCAFE);
    chk(halted, "R10", "halted stays high", {31'd0, halted}, 1);
  endtask

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "ALL", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_add();
    t_sub_nz();
    t_sub_z();
    t_cond_other();
    t_mov();
    t_halt(6'd3);
    t_halt(6'd7);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule